// File: doc/BRIEF.md
# Page Half Swapper

The page half swapper repairs a 4 KB page of memory after the page has moved to a new physical address. One command names one page. The command gives the page base address, a flag that was saved earlier, and the new physical address. The saved flag is bit 17 of the physical address the page had when the flag was saved. If that flag matches bit 17 of the new address, nothing needs to be done and the block answers at once. If the two bits differ, the block walks the whole page in 128-byte blocks. In each block it exchanges the lower 64 bytes with the upper 64 bytes, then reports that the page was modified.

All data moves through one synchronous RAM port, one 32-bit word per cycle, with one cycle of read latency. Each block is handled in three phases:

- the lower half is read into a 16-word holding buffer;
- each upper-half word is read and written down into the lower half;
- the buffer is written into the upper half.

A start/busy/done handshake carries the command. A caller waits for `done` and then reads `pageDirty`.

Top module: `pageHalfSwapper`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `pageDirty` and `memEn` are all 0.
- R2: A command is taken on a rising edge where `start` is 1 and `busy` is 0. Bits 11:0 of `pageBase` are ignored, so the page used is `pageBase[31:12]`.
- R3: If `savedFlag` equals `newPhys[17]`, `done` is 1 in the first cycle after the accepting edge. No memory access is made, and `pageDirty` is 0.
- R4: If `savedFlag` differs from `newPhys[17]`, every 128-byte block of the page ends with its bytes 0..63 and bytes 64..127 exchanged. The word order inside each half is kept: word w of a block moves to word w±16.
- R5: Every access has `memAddr[1:0]` equal to 0 and lies inside the commanded page. Memory outside that page is left unchanged.
- R6: After a swap, `pageDirty` is 1 in the `done` cycle and stays 1 until the next command is accepted. Accepting a command clears it.
- R7: A swap keeps `memEn` high in each of the 2048 cycles after the accepting edge, and `done` rises in cycle 2049. `busy` is 1 from the cycle after acceptance through the `done` cycle. `done` lasts one cycle.
- R8: A `start` pulse raised while `busy` is 1 is ignored. It neither changes the page being processed nor starts a later command.
- R9: The RAM port returns read data in the cycle after a read with `memWe` low. `memEn` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request |
| pageBase | input | 32 | Byte address of the page; low 12 bits ignored |
| savedFlag | input | 1 | Bit 17 of the page's address when the flag was saved |
| newPhys | input | 32 | New physical address of the page |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pageDirty | output | 1 | Page contents were rewritten |
| memEn | output | 1 | RAM access this cycle |
| memWe | output | 1 | RAM access is a write |
| memAddr | output | 32 | RAM byte address, word aligned |
| memWdata | output | 32 | RAM write data |
| memRdata | input | 32 | RAM read data, valid one cycle after the read |

## Verification
The case that is hardest to reach from the ports is a second `start` arriving in the middle of a page swap. That `start` points at another page, and its flags would also call for a swap. The bench reaches it by raising such a request 100 cycles into a swap and holding it for two cycles. It then confirms three things: the cycle-by-cycle model still matches, the intruding page is untouched, and the timing of `done` is unchanged. Running the same page twice also shows that a double swap restores the original contents.

// File: rtl/halfSwapPkg.sv
package halfSwapPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_LO,
    ST_FETCH_HI,
    ST_STORE_LO,
    ST_STORE_HI,
    ST_FIN
  } swapState_e;

  // Strobes from control to datapath, valid in the current cycle
  typedef struct packed {
    logic latch;      // capture a new command
    logic memEn;      // RAM access this cycle
    logic memWe;      // access is a write
    logic upperHalf;  // address the 64..127 half of the block
    logic fromHold;   // write data comes from the holding buffer
    logic markDirty;  // last write of the page
  } swapStrobes_t;

endpackage

// File: rtl/swapControl.sv
module swapControl
  import halfSwapPkg::*;
#(
  parameter int BLOCKS     = 32,
  parameter int HALF_WORDS = 16,
  localparam int BLK_W     = $clog2(BLOCKS),
  localparam int WORD_W    = $clog2(HALF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              savedFlag,
  input  logic              newPhysBit,
  output logic              busy,
  output logic              done,
  output swapStrobes_t      strobes,
  output logic [BLK_W-1:0]  blkIdx,
  output logic [WORD_W-1:0] wordIdx,
  output logic              capValid,
  output logic [WORD_W-1:0] capIdx
);

  swapState_e state;
  logic lastWord, lastBlk;

  assign lastWord = (wordIdx == WORD_W'(HALF_WORDS - 1));
  assign lastBlk  = (blkIdx == BLK_W'(BLOCKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wordIdx  <= '0;
      blkIdx   <= '0;
      capValid <= 1'b0;
      capIdx   <= '0;
    end else begin
      // read data of a lower-half load lands one cycle later
      capValid <= (state == ST_LOAD_LO);
      capIdx   <= wordIdx;
      case (state)
        ST_IDLE: begin
          if (start) begin
            wordIdx <= '0;
            blkIdx  <= '0;
            state   <= (savedFlag != newPhysBit) ? ST_LOAD_LO : ST_FIN;
          end
        end
        ST_LOAD_LO: begin
          if (lastWord) begin
            wordIdx <= '0;
            state   <= ST_FETCH_HI;
          end else begin
            wordIdx <= wordIdx + 1'b1;
          end
        end
        ST_FETCH_HI: state <= ST_STORE_LO;
        ST_STORE_LO: begin
          if (lastWord) begin
            wordIdx <= '0;
            state   <= ST_STORE_HI;
          end else begin
            wordIdx <= wordIdx + 1'b1;
            state   <= ST_FETCH_HI;
          end
        end
        ST_STORE_HI: begin
          if (lastWord) begin
            wordIdx <= '0;
            if (lastBlk) begin
              state <= ST_FIN;
            end else begin
              blkIdx <= blkIdx + 1'b1;
              state  <= ST_LOAD_LO;
            end
          end else begin
            wordIdx <= wordIdx + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.latch     = (state == ST_IDLE) && start;
    strobes.memEn     = (state == ST_LOAD_LO) || (state == ST_FETCH_HI) ||
                        (state == ST_STORE_LO) || (state == ST_STORE_HI);
    strobes.memWe     = (state == ST_STORE_LO) || (state == ST_STORE_HI);
    strobes.upperHalf = (state == ST_FETCH_HI) || (state == ST_STORE_HI);
    strobes.fromHold  = (state == ST_STORE_HI);
    strobes.markDirty = (state == ST_STORE_HI) && lastWord && lastBlk;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/swapDatapath.sv
module swapDatapath
  import halfSwapPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int HALF_WORDS = 16,
  parameter int BLOCKS     = 32,
  localparam int BLK_W     = $clog2(BLOCKS),
  localparam int WORD_W    = $clog2(HALF_WORDS),
  localparam int BYTE_SH   = $clog2(DATA_W / 8),
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapStrobes_t      strobes,
  input  logic [BLK_W-1:0]  blkIdx,
  input  logic [WORD_W-1:0] wordIdx,
  input  logic              capValid,
  input  logic [WORD_W-1:0] capIdx,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              pageDirty
);

  logic [PAGE_W-1:0] pageReg;
  logic [DATA_W-1:0] holdBuf [HALF_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg   <= '0;
      pageDirty <= 1'b0;
    end else if (strobes.latch) begin
      pageReg   <= pageNum;
      pageDirty <= 1'b0;
    end else if (strobes.markDirty) begin
      pageDirty <= 1'b1;
    end
  end

  // one holding register per lower-half word
  for (genvar i = 0; i < HALF_WORDS; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (capValid && (capIdx == WORD_W'(i))) holdBuf[i] <= memRdata;
    end
  end

  assign memEn    = strobes.memEn;
  assign memWe    = strobes.memWe;
  assign memAddr  = {pageReg, blkIdx, strobes.upperHalf, wordIdx, {BYTE_SH{1'b0}}};
  assign memWdata = strobes.fromHold ? holdBuf[wordIdx] : memRdata;

endmodule

// File: rtl/pageHalfSwapper.sv
module pageHalfSwapper
  import halfSwapPkg::*;
#(
  parameter int PAGE_BYTES  = 4096,
  parameter int BLOCK_BYTES = 128,
  parameter int ADDR_W      = 32,
  parameter int FLAG_BIT    = 17,
  localparam int DATA_W     = 32,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int HALF_WORDS = BLOCK_BYTES / 2 / WORD_BYTES,
  localparam int BLOCKS     = PAGE_BYTES / BLOCK_BYTES,
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
  localparam int BLK_W      = $clog2(BLOCKS),
  localparam int WORD_W     = $clog2(HALF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] pageBase,
  input  logic              savedFlag,
  input  logic [ADDR_W-1:0] newPhys,
  output logic              busy,
  output logic              done,
  output logic              pageDirty,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  swapStrobes_t      strobes;
  logic [BLK_W-1:0]  blkIdx;
  logic [WORD_W-1:0] wordIdx;
  logic              capValid;
  logic [WORD_W-1:0] capIdx;
  logic              unusedIgnored;

  // offset bits of the base and the remaining address bits play no part
  assign unusedIgnored = ^{pageBase[PAGE_SHIFT-1:0], newPhys};

  swapControl #(
    .BLOCKS(BLOCKS), .HALF_WORDS(HALF_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .savedFlag(savedFlag),
    .newPhysBit(newPhys[FLAG_BIT]), .busy(busy), .done(done),
    .strobes(strobes), .blkIdx(blkIdx), .wordIdx(wordIdx),
    .capValid(capValid), .capIdx(capIdx)
  );

  swapDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT),
    .HALF_WORDS(HALF_WORDS), .BLOCKS(BLOCKS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .blkIdx(blkIdx),
    .wordIdx(wordIdx), .capValid(capValid), .capIdx(capIdx),
    .pageNum(pageBase[ADDR_W-1:PAGE_SHIFT]), .memRdata(memRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .pageDirty(pageDirty)
  );

endmodule

// File: rtl/pageHalfSwapperChecks.sv
module pageHalfSwapperChecks #(
  parameter int ADDR_W     = 32,
  parameter int FLAG_BIT   = 17,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] pageBase,
  input logic              savedFlag,
  input logic [ADDR_W-1:0] newPhys,
  input logic              busy,
  input logic              done,
  input logic              pageDirty,
  input logic              memEn,
  input logic [ADDR_W-1:0] memAddr
);

  logic [ADDR_W-PAGE_SHIFT-1:0] expPage;
  logic expDirty;
  logic accept, mismatch;

  assign accept   = start && !busy;
  assign mismatch = savedFlag != newPhys[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expPage  <= '0;
      expDirty <= 1'b0;
    end else if (accept) begin
      expPage  <= pageBase[ADDR_W-1:PAGE_SHIFT];
      expDirty <= mismatch;
    end
  end

  assert_quick_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !mismatch) |=> (done && !memEn && !pageDirty));

  assert_swap_starts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && mismatch) |=> (busy && !done && memEn));

  assert_in_page_R5: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (memAddr[ADDR_W-1:PAGE_SHIFT] == expPage && memAddr[1:0] == 2'b00));

  assert_dirty_at_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pageDirty == expDirty));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memEn);

endmodule

bind pageHalfSwapper pageHalfSwapperChecks #(
  .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT), .PAGE_SHIFT(PAGE_SHIFT)
) u_checks (
  .clk(clk), .rstN(rstN), .start(start), .pageBase(pageBase),
  .savedFlag(savedFlag), .newPhys(newPhys), .busy(busy), .done(done),
  .pageDirty(pageDirty), .memEn(memEn), .memAddr(memAddr)
);

// File: tb/test_pageHalfSwapper.sv
`timescale 1ns/1ps
module test_pageHalfSwapper;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [31:0] pageBase;
  logic        savedFlag;
  logic [31:0] newPhys;
  logic        busy, done, pageDirty, memEn, memWe;
  logic [31:0] memAddr, memWdata, memRdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] mem [int unsigned];
  logic [31:0] expMem [int unsigned];

  always #2.5 clk = ~clk;

  pageHalfSwapper i_pageHalfSwapper (
    .clk(clk), .rstN(rstN), .start(start), .pageBase(pageBase),
    .savedFlag(savedFlag), .newPhys(newPhys), .busy(busy), .done(done),
    .pageDirty(pageDirty), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // RAM model, one-cycle read latency (R9)
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr >> 2] = memWdata;
      else memRdata <= mem.exists(memAddr >> 2) ? mem[memAddr >> 2] : 32'hDEAD_BEEF;
    end
  end

  // behavioural reference model of the handshake
  bit mBusy, mDone, mDirty, mSwap;
  int mCnt;
  logic [19:0] mPage;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mDirty = 0; mSwap = 0; mCnt = 0; mPage = '0;
    end else if (mDone) begin
      mDone = 0; mBusy = 0;
    end else if (mBusy) begin
      mCnt--;
      if (mCnt == 1) begin mDone = 1; mDirty = mSwap; end
    end else if (start) begin
      mSwap  = (savedFlag != newPhys[17]);
      mCnt   = mSwap ? 2049 : 1;
      mBusy  = 1;
      mDirty = 0;
      mPage  = pageBase[31:12];
      if (mCnt == 1) begin mDone = 1; mDirty = mSwap; end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (busy !== mBusy) begin
        errors++; $display("FAIL R7 busy actual %0b expected %0b at %0t", busy, mBusy, $time);
      end
      checks++;
      if (done !== mDone) begin
        errors++; $display("FAIL R7 done actual %0b expected %0b at %0t", done, mDone, $time);
      end
      checks++;
      if (pageDirty !== mDirty) begin
        errors++; $display("FAIL R6 pageDirty actual %0b expected %0b at %0t", pageDirty, mDirty, $time);
      end
      checks++;
      if (memEn !== (mBusy && mSwap && !mDone)) begin
        errors++; $display("FAIL R9 memEn actual %0b expected %0b at %0t", memEn, (mBusy && mSwap && !mDone), $time);
      end
      if (memEn === 1'b1) begin
        checks++;
        if (memAddr[31:12] !== mPage || memAddr[1:0] !== 2'b00) begin
          errors++; $display("FAIL R5 memAddr actual %h expected page %h at %0t", memAddr, mPage, $time);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fillPages();
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < 1024; w++) begin
        mem[p * 1024 + w]    = {8'(8'hA0 + p), 12'(w * 7), 12'(w)};
        expMem[p * 1024 + w] = mem[p * 1024 + w];
      end
  endtask

  // exchange word w with w+16 in every 32-word block (R4)
  task automatic swapExpected(input int p);
    for (int b = 0; b < 32; b++)
      for (int w = 0; w < 16; w++) begin
        logic [31:0] t;
        int lo = p * 1024 + b * 32 + w;
        t = expMem[lo];
        expMem[lo] = expMem[lo + 16];
        expMem[lo + 16] = t;
      end
  endtask

  task automatic checkPages(input string req);
    for (int p = 0; p < 3; p++) begin
      int bad = -1;
      for (int w = 0; w < 1024; w++)
        if (bad < 0 && mem[p * 1024 + w] !== expMem[p * 1024 + w]) bad = w;
      checks++;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s page %0d word %0d actual %h expected %h", req, p, bad,
                 mem[p * 1024 + bad], expMem[p * 1024 + bad]);
      end
    end
  endtask

  task automatic runCmd(input logic [31:0] base, input logic flag, input logic [31:0] phys,
                        input int expCycles, input bit intrude);
    int n;
    @(negedge clk);
    pageBase = base; savedFlag = flag; newPhys = phys; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (done !== 1'b1) begin
      @(negedge clk);
      n++;
      if (intrude && n == 100) begin  // R8: request for page 2 while busy
        pageBase = 32'h0000_2000; savedFlag = 1'b0; newPhys = 32'h0002_0000; start = 1'b1;
      end
      if (intrude && n == 102) start = 1'b0;
    end
    checks++;
    if (n != expCycles) begin
      errors++; $display("FAIL R7 done latency actual %0d expected %0d", n, expCycles);
    end
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; pageBase = '0; savedFlag = 1'b0; newPhys = '0; memRdata = '0;
    fillPages();
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({busy, done, pageDirty, memEn} !== 4'b0000) begin
      errors++; $display("FAIL R1 outputs actual %b expected 0000", {busy, done, pageDirty, memEn});
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if ({busy, done, pageDirty, memEn} !== 4'b0000) begin
      errors++; $display("FAIL R1 after release actual %b expected 0000", {busy, done, pageDirty, memEn});
    end

    // R3: matching flags, both 0
    runCmd(32'h0000_0000, 1'b0, 32'h0000_0000, 1, 0);
    checks++;
    if (pageDirty !== 1'b0) begin errors++; $display("FAIL R3 pageDirty actual %0b expected 0", pageDirty); end
    checkPages("R3");

    // R2 R4 R5: swap page 1 given an unaligned base
    runCmd(32'h0000_1ABC, 1'b0, 32'h0002_0000, 2049, 0);
    swapExpected(1);
    checkPages("R4");
    repeat (5) @(negedge clk);
    checks++;
    if (pageDirty !== 1'b1) begin errors++; $display("FAIL R6 held pageDirty actual %0b expected 1", pageDirty); end

    // R3 R6: matching flags, both 1, clears dirty
    runCmd(32'h0000_2000, 1'b1, 32'h0003_5000, 1, 0);
    checks++;
    if (pageDirty !== 1'b0) begin errors++; $display("FAIL R6 cleared pageDirty actual %0b expected 0", pageDirty); end
    checkPages("R3");

    // R8: swap page 0 with an intruding request for page 2
    runCmd(32'h0000_0000, 1'b1, 32'h0001_F000, 2049, 1);
    swapExpected(0);
    checkPages("R8");
    repeat (4) @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin errors++; $display("FAIL R8 busy after ignored start actual %0b expected 0", busy); end

    // R4: swapping page 1 again restores it
    runCmd(32'h0000_1000, 1'b0, 32'hFFFF_FFFF, 2049, 0);
    swapExpected(1);
    checkPages("R4");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule